// File: doc/BRIEF.md
# Single-Wire Slave Bit Interface

This block is the device-side bit layer of a single-wire, open-drain bus. It watches the line through a two-flop synchroniser and recognises a reset when the line stays low long enough. After the line rises again it waits briefly, then pulls the line low for a fixed time as its presence answer. Between resets, every falling edge opens a time slot. A single slot timer measures from that edge. In receive mode it samples the line once, part way into the slot. In transmit mode it holds the line low for the first part of the slot when the bit to send is 0.

Bits travel least significant first. A command layer above this block picks the direction and supplies the outgoing byte before the first slot of each byte. After eight slots the block strobes either a received byte or a transmit-complete pulse. All times are given in microseconds and converted to clock cycles through a ticks-per-microsecond parameter. The bus appears as a pull-low enable (`line_pull`) and a raw line input (`line_in`).

States and transitions:
- `ST_IDLE` goes to `ST_SLOT` on a falling edge.
- `ST_SLOT` goes to `ST_RECOVER` when the sample point is reached.
- `ST_RECOVER` goes to `ST_IDLE` once the line is high.
- Any state goes to `ST_RST_LOW` when the low-time limit is reached.
- `ST_RST_LOW` goes to `ST_PD_WAIT` when the line rises, and strobes `bus_reset` in that cycle.
- `ST_PD_WAIT` goes to `ST_PD_DRIVE` after the presence delay.
- `ST_PD_DRIVE` goes to `ST_RECOVER` after the presence length.

Top module: `swire_slave_phy`

## Requirements
- R1: After reset, `line_pull`, `rx_strobe`, `tx_strobe` and `bus_reset` are all 0.
- R2: A synchronised low level that lasts RST_MIN_US (480 µs) is a bus reset. When the line next goes high, `bus_reset` pulses for one cycle and the bit count is 0, so a partly received byte is dropped.
- R3: After a bus reset, the line stays released for PD_WAIT_US (30 µs), and then `line_pull` is held for PD_LEN_US (120 µs).
- R4: In receive mode, the line is sampled SAMPLE_US (30 µs) after each detected falling edge. A high sample is bit value 1 and a low sample is bit value 0.
- R5: Received bits fill the byte from bit 0 up to bit 7. After the eighth sample, `rx_strobe` is high for exactly one cycle, and `rx_data` holds the byte.
- R6: In transmit mode, a 0 bit asserts `line_pull` from the detected falling edge for RD_HOLD_US (15 µs). A 1 bit never asserts `line_pull`.
- R7: Transmitted bits go out from bit 0 up to bit 7 of `tx_data`. After the eighth slot, `tx_strobe` is high for exactly one cycle. `rx_strobe` and `tx_strobe` are never high together.
- R8: `tx_mode` and `tx_data` are captured only at the first slot of a byte. Changes to them during the remaining slots of that byte have no effect.
- R9: `line_pull` is never asserted in `ST_IDLE`, `ST_RECOVER`, `ST_RST_LOW` or `ST_PD_WAIT`, nor during any receive-mode slot.
- R10: A bus reset in the middle of a byte discards the bits received so far. The next eight slots form a complete new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, TICKS_PER_US cycles per microsecond |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Raw bus level (1 = high) |
| line_pull | output | 1 | 1 = pull the bus low (open-drain enable) |
| tx_mode | input | 1 | Direction for the next byte: 1 = send, 0 = receive |
| tx_data | input | BYTE_W | Byte to send, captured at the first slot |
| rx_data | output | BYTE_W | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse: `rx_data` holds a new byte |
| tx_strobe | output | 1 | One-cycle pulse: a byte has been sent |
| bus_reset | output | 1 | One-cycle pulse at the rising edge that ends a bus reset |

## Verification
The checker verifies every cycle that the strobes last one cycle each and never occur together. It checks that no pull run lasts longer than the presence length and that the line stays released in the waiting and idle states. It also checks that the bit count is zero whenever `bus_reset` pulses. Only the bench scenarios can show the actual slot timing and data: where the presence pulse begins and ends as seen on the wired line, how written levels turn into bytes in bit order, and how read-0 and read-1 slots look to a master sampling at 4 µs and 12 µs. The same applies to ignoring direction and data changes in the middle of a byte, and to dropping a partial byte after a bus reset.

// File: rtl/swire_pkg.sv
package swire_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RECOVER,
        ST_RST_LOW,
        ST_PD_WAIT,
        ST_PD_DRIVE
    } swire_state_t;
endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-1:0], din};
    end

    assign lvl  = pipe[STAGES-1];
    assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/swire_low_timer.sv
module swire_low_timer #(
    parameter int LIMIT = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic hit
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (lvl)               cnt <= '0;
        else if (cnt != W'(LIMIT))  cnt <= cnt + W'(1);
    end

    assign hit = !lvl && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/swire_shifter.sv
module swire_shifter #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 start,
    input  logic                 sample,
    input  logic                 din,
    input  logic                 tx_mode,
    input  logic [W-1:0]         tx_data,
    output logic                 dir,
    output logic                 cur_bit,
    output logic [$clog2(W)-1:0] bitcnt,
    output logic [W-1:0]         rx_data,
    output logic                 rx_strobe,
    output logic                 tx_strobe
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            dir       <= 1'b0;
            bitcnt    <= '0;
            rx_data   <= '0;
            rx_strobe <= 1'b0;
            tx_strobe <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            tx_strobe <= 1'b0;
            if (clear) begin
                bitcnt <= '0;
            end else begin
                if (start && bitcnt == '0) begin
                    dir <= tx_mode;
                    if (tx_mode) sh <= tx_data;
                end
                if (sample) begin
                    sh <= {din, sh[W-1:1]};
                    if (bitcnt == LAST) begin
                        bitcnt <= '0;
                        if (dir) begin
                            tx_strobe <= 1'b1;
                        end else begin
                            rx_strobe <= 1'b1;
                            rx_data   <= {din, sh[W-1:1]};
                        end
                    end else begin
                        bitcnt <= bitcnt + CW'(1);
                    end
                end
            end
        end
    end

    assign cur_bit = sh[0];
endmodule

// File: rtl/swire_slave_phy.sv
module swire_slave_phy #(
    parameter int TICKS_PER_US = 4,
    parameter int RST_MIN_US   = 480,
    parameter int PD_WAIT_US   = 30,
    parameter int PD_LEN_US    = 120,
    parameter int SAMPLE_US    = 30,
    parameter int RD_HOLD_US   = 15,
    parameter int BYTE_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              line_pull,
    input  logic              tx_mode,
    input  logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_strobe,
    output logic              tx_strobe,
    output logic              bus_reset
);
    import swire_pkg::*;

    localparam int RST_CYC  = RST_MIN_US * TICKS_PER_US;
    localparam int PDW_CYC  = PD_WAIT_US * TICKS_PER_US;
    localparam int PDL_CYC  = PD_LEN_US  * TICKS_PER_US;
    localparam int SMP_CYC  = SAMPLE_US  * TICKS_PER_US;
    localparam int HOLD_CYC = RD_HOLD_US * TICKS_PER_US;
    localparam int TW       = $clog2(RST_CYC + 1);
    localparam int BCW      = $clog2(BYTE_W);

    swire_state_t    state, nxt;
    logic [TW-1:0]   tcnt;
    logic            lvl, fall, rst_hit;
    logic            dir, cur_bit;
    logic [BCW-1:0]  bitcnt;
    logic            slot_start, slot_sample;

    swire_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_in),
        .lvl  (lvl),
        .fall (fall)
    );

    swire_low_timer #(.LIMIT(RST_CYC)) u_low (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl),
        .hit  (rst_hit)
    );

    assign slot_start  = (state == ST_IDLE) && (nxt == ST_SLOT);
    assign slot_sample = (state == ST_SLOT) && (nxt == ST_RECOVER);

    swire_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rst_hit),
        .start    (slot_start),
        .sample   (slot_sample),
        .din      (lvl),
        .tx_mode  (tx_mode),
        .tx_data  (tx_data),
        .dir      (dir),
        .cur_bit  (cur_bit),
        .bitcnt   (bitcnt),
        .rx_data  (rx_data),
        .rx_strobe(rx_strobe),
        .tx_strobe(tx_strobe)
    );

    // next-state decode
    always_comb begin
        nxt = state;
        if (rst_hit) begin
            nxt = ST_RST_LOW;
        end else begin
            unique case (state)
                ST_IDLE:     if (fall) nxt = ST_SLOT;
                ST_SLOT:     if (tcnt == TW'(SMP_CYC - 1)) nxt = ST_RECOVER;
                ST_RECOVER:  if (lvl) nxt = ST_IDLE;
                ST_RST_LOW:  if (lvl) nxt = ST_PD_WAIT;
                ST_PD_WAIT:  if (tcnt == TW'(PDW_CYC - 1)) nxt = ST_PD_DRIVE;
                ST_PD_DRIVE: if (tcnt == TW'(PDL_CYC - 1)) nxt = ST_RECOVER;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // slot / presence timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tcnt <= '0;
        else if (nxt != state)
            tcnt <= '0;
        else if (state == ST_SLOT || state == ST_PD_WAIT || state == ST_PD_DRIVE)
            tcnt <= tcnt + TW'(1);
        else
            tcnt <= '0;
    end

    // outputs
    always_comb begin
        line_pull = 1'b0;
        bus_reset = 1'b0;
        unique case (state)
            ST_PD_DRIVE: line_pull = 1'b1;
            ST_SLOT:     line_pull = dir && !cur_bit && (tcnt < TW'(HOLD_CYC));
            ST_RST_LOW:  bus_reset = lvl;
            default:     ;
        endcase
    end
endmodule

// File: rtl/swire_slave_phy_chk.sv
module swire_slave_phy_chk #(
    parameter int TICKS_PER_US = 4,
    parameter int PD_LEN_US    = 120,
    parameter int RD_HOLD_US   = 15,
    parameter int BYTE_W       = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      line_pull,
    input logic                      rx_strobe,
    input logic                      tx_strobe,
    input logic                      bus_reset,
    input swire_pkg::swire_state_t   state,
    input logic [$clog2(BYTE_W)-1:0] bitcnt
);
    import swire_pkg::*;

    localparam int MAXP = (PD_LEN_US > RD_HOLD_US ? PD_LEN_US : RD_HOLD_US) * TICKS_PER_US;

    logic [31:0] pull_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pull_run <= '0;
        else if (line_pull) pull_run <= pull_run + 32'd1;
        else                pull_run <= '0;
    end

    a_r5_rx_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    a_r7_tx_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |=> !tx_strobe);

    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_strobe && tx_strobe));

    a_r6_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> (pull_run < 32'(MAXP)));

    a_r3_quiet_before_presence: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PD_WAIT) |-> !line_pull);

    a_r9_no_pull_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_RECOVER || state == ST_RST_LOW) |-> !line_pull);

    a_r2_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |-> (bitcnt == '0));
endmodule

bind swire_slave_phy swire_slave_phy_chk #(
    .TICKS_PER_US(TICKS_PER_US),
    .PD_LEN_US   (PD_LEN_US),
    .RD_HOLD_US  (RD_HOLD_US),
    .BYTE_W      (BYTE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_pull(line_pull),
    .rx_strobe(rx_strobe),
    .tx_strobe(tx_strobe),
    .bus_reset(bus_reset),
    .state    (state),
    .bitcnt   (bitcnt)
);

// File: tb/swire_slave_phy_test.sv
module swire_slave_phy_test;
    localparam int CLK_PERIOD = 10;
    localparam int TPU        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mpull = 1'b0;
    logic       tx_mode = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       line_pull;
    logic [7:0] rx_data;
    logic       rx_strobe, tx_strobe, bus_reset;
    logic       line;

    int n_chk = 0;
    int n_bad = 0;
    int rx_seen = 0;
    int tx_seen = 0;
    int rst_seen = 0;
    logic [7:0] rx_last = 8'h00;

    assign line = ~(mpull | line_pull);

    always #(CLK_PERIOD/2) clk = ~clk;

    swire_slave_phy #(.TICKS_PER_US(TPU)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line),
        .line_pull(line_pull),
        .tx_mode  (tx_mode),
        .tx_data  (tx_data),
        .rx_data  (rx_data),
        .rx_strobe(rx_strobe),
        .tx_strobe(tx_strobe),
        .bus_reset(bus_reset)
    );

    always @(posedge clk) begin
        if (rx_strobe) begin
            rx_seen <= rx_seen + 1;
            rx_last <= rx_data;
        end
        if (tx_strobe) tx_seen  <= tx_seen + 1;
        if (bus_reset) rst_seen <= rst_seen + 1;
    end

    function automatic logic exp_bit(logic [7:0] v, int i);
        return v[i];
    endfunction

    function automatic logic [7:0] exp_byte_after_partial(logic [7:0] v);
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_us(int us);
        repeat (us * TPU) @(negedge clk);
    endtask

    task automatic bus_reset_seq();
        int pre;
        pre = rst_seen;
        mpull = 1'b1;
        wait_us(500);
        mpull = 1'b0;
        wait_us(10);
        check("R2 reset strobe count", rst_seen, pre + 1);
        check("R3 released before presence", line, 1'b1);
        wait_us(40);
        check("R3 presence low at 50us", line, 1'b0);
        wait_us(90);
        check("R3 presence low at 140us", line, 1'b0);
        wait_us(40);
        check("R3 presence over at 180us", line, 1'b1);
        wait_us(80);
    endtask

    task automatic write_bit(logic b);
        mpull = 1'b1;
        wait_us(5);
        if (b) mpull = 1'b0;
        wait_us(15);
        if (b) check("R9 no pull in receive slot", line, 1'b1);
        wait_us(45);
        mpull = 1'b0;
        wait_us(7);
    endtask

    task automatic write_byte(logic [7:0] v);
        int pre;
        tx_mode = 1'b0;
        pre = rx_seen;
        for (int i = 0; i < 8; i++) write_bit(exp_bit(v, i));
        check("R5 one rx strobe per byte", rx_seen, pre + 1);
        check("R4 R5 received byte", rx_last, v);
    endtask

    task automatic read_bit(logic expb, output logic got);
        mpull = 1'b1;
        wait_us(1);
        mpull = 1'b0;
        wait_us(3);
        check("R6 slave drive at 4us", line, expb);
        wait_us(8);
        got = line;
        wait_us(58);
    endtask

    task automatic read_byte(logic [7:0] v, logic [7:0] alt, logic disturb);
        int pre_tx, pre_rx;
        logic [7:0] got;
        logic b;
        tx_mode = 1'b1;
        tx_data = v;
        pre_tx = tx_seen;
        pre_rx = rx_seen;
        for (int i = 0; i < 8; i++) begin
            if (disturb && i == 1) begin
                tx_data = alt;
                tx_mode = 1'b0;
            end
            read_bit(exp_bit(v, i), b);
            got[i] = b;
        end
        check(disturb ? "R8 mid-byte change ignored" : "R7 sent byte", got, v);
        check("R7 one tx strobe per byte", tx_seen, pre_tx + 1);
        check("R7 no rx strobe while sending", rx_seen, pre_rx);
        tx_mode = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pre;
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (5) @(negedge clk);
        check("R1 pull after reset", line_pull, 1'b0);
        check("R1 rx strobe after reset", rx_strobe, 1'b0);
        check("R1 tx strobe after reset", tx_strobe, 1'b0);
        check("R1 bus reset after reset", bus_reset, 1'b0);
        rst_n = 1'b1;
        wait_us(5);
        check("R1 line released", line, 1'b1);

        bus_reset_seq();

        write_byte(8'h00);
        write_byte(8'hFF);
        write_byte(8'h01);
        read_byte(8'h00, 8'hFF, 1'b0);
        read_byte(8'hFF, 8'h00, 1'b0);
        read_byte(8'hA5, 8'h5A, 1'b1);

        // R10: partial byte dropped by a bus reset
        tx_mode = 1'b0;
        pre = rx_seen;
        write_bit(1'b1);
        write_bit(1'b1);
        write_bit(1'b1);
        bus_reset_seq();
        check("R10 no strobe from partial byte", rx_seen, pre);
        write_byte(exp_byte_after_partial(8'h3C));

        for (int k = 0; k < 12; k++) begin
            v = 8'($urandom);
            if ($urandom % 2 == 0) write_byte(v);
            else read_byte(v, 8'($urandom), 1'($urandom % 2));
        end

        bus_reset_seq();
        write_byte(8'h80);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule